// File: doc/BRIEF.md
# Horizontal Character Column Timer

This block produces the horizontal timing for an on-screen character overlay of 30 columns. It runs on the pixel clock. It watches the incoming horizontal flyback pulse and waits a programmable offset after each leading edge. It then walks through the character cells of the line, giving the current column number, the dot position inside the cell and an enable that frames the visible run. Downstream font and colour logic uses these three outputs to fetch and shade pixels. Pixel clock generation is outside this block.

The offset is six pixel clocks per step of the position setting, plus a fixed 49. The line length is twelve pixel clocks per step of the resolution setting, and any visible dot at or past that point is suppressed. A per-row wide flag doubles every cell to 24 dots. In that mode the odd columns are skipped rather than shown stretched, so the visible run still lasts 360 pixel clocks. The position, resolution and wide settings are captured when the leading edge is detected. Each new leading edge restarts the line, even when the previous line is still showing.

Top module: `osd_col_timer`

## Requirements
- R1: The flyback input passes through a two-stage synchroniser and only its low-to-high transition starts a line. Number as 0 the first rising clock edge that samples it high. The first visible dot (disp_en=1, col_idx=0, dot_idx=0) is then present after rising edge hpos*6+49+3.
- R2: The start offset after the detected edge is exactly hpos*6+49 pixel clocks, for every value of hpos.
- R3: In normal width, col_idx counts 0 to 29 and dot_idx counts 0 to 11 within each column. col_idx advances when dot_idx wraps, and disp_en stays high for 360 consecutive cycles.
- R4: With the wide flag captured as 1, each cell lasts 24 cycles and col_idx takes only the even values 0, 2, ..., 28. dot_idx equals the position inside the cell divided by two (0 to 11), and the run still lasts 360 cycles.
- R5: A line is hres*12 pixel clocks long, counted from the detected edge (position 0). disp_en is low at every position of hres*12 or more, even when the 360-dot run has not finished.
- R6: A new leading edge ends any run in progress: disp_en is low from the cycle in which the edge takes effect, and the offset count restarts from it.
- R7: While disp_en is low, col_idx and dot_idx both read 0.
- R8: hpos, hres and the wide flag are sampled only at the detected edge. Changing them later in the line has no effect on that line.
- R9: After reset, and until the first leading edge, disp_en, col_idx and dot_idx are 0.
- R10: Holding the flyback input high for many cycles does not start the line again. Only a fresh low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flyback | input | 1 | Horizontal flyback pulse, asynchronous, leading edge active high |
| hpos | input | 8 | Horizontal position setting (offset = hpos*6+49) |
| hres | input | 8 | Horizontal resolution setting (line = hres*12 dots) |
| wide_row | input | 1 | Double-width flag of the current row |
| disp_en | output | 1 | High during visible character dots |
| col_idx | output | 5 | Current column, 0 to 29 |
| dot_idx | output | 4 | Dot inside the character, 0 to 11 |

## Verification
The bench builds the block with its default parameters: 8-bit position and resolution fields, 30 columns of 12 dots and a two-stage synchroniser. These defaults give offsets up to 1579 dots and lines up to 3060 dots, so random lines reach both lines that end well after the run and short lines that cut it off or never show it. Directed lines cover the smallest offset, a line shorter than the offset, a flyback that arrives in the middle of the run, a flyback held high for a long time, and settings changed in the middle of a line in both widths.

// File: rtl/osd_col_timer_pkg.sv
package osd_col_timer_pkg;

  typedef enum logic [0:0] {
    CS_IDLE = 1'b0,
    CS_SHOW = 1'b1
  } col_state_e;

  // Width of the pixel position counter: wide enough for the longest line
  // and the largest start offset, with headroom for one extra count.
  function automatic int pix_width(input int hpos_w, input int hres_w,
                                   input int dots, input int ofs_mul,
                                   input int ofs_add);
    int len_max;
    int ofs_max;
    int top;
    int w;
    len_max = ((1 << hres_w) - 1) * dots;
    ofs_max = ((1 << hpos_w) - 1) * ofs_mul + ofs_add;
    top     = (len_max > ofs_max) ? len_max : ofs_max;
    top     = top + 2;
    w       = 1;
    while ((1 << w) < top) w = w + 1;
    return w;
  endfunction

endpackage

// File: rtl/osd_col_sync.sv
module osd_col_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise_pulse = chain[STAGES-1] & ~last_q;

  // A level held high yields a single pulse only.
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/osd_col_line.sv
module osd_col_line #(
  parameter int HPOS_W  = 8,
  parameter int HRES_W  = 8,
  parameter int DOTS    = 12,
  parameter int OFS_MUL = 6,
  parameter int OFS_ADD = 49,
  parameter int PIX_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_pulse,
  input  logic [HPOS_W-1:0] hpos,
  input  logic [HRES_W-1:0] hres,
  input  logic              wide_in,
  output logic              start_hit,
  output logic              line_end,
  output logic              wide_q
);

  logic [PIX_W-1:0] pix;
  logic [PIX_W-1:0] start_q;
  logic [PIX_W-1:0] len_q;
  logic             running;
  logic [PIX_W:0]   pix_next;
  logic [PIX_W-1:0] start_calc;
  logic [PIX_W-1:0] len_calc;

  assign start_calc = PIX_W'(hpos) * PIX_W'(OFS_MUL) + PIX_W'(OFS_ADD);
  assign len_calc   = PIX_W'(hres) * PIX_W'(DOTS);
  assign pix_next   = {1'b0, pix} + {{PIX_W{1'b0}}, 1'b1};

  // The line is over once the next position would reach the line length.
  assign line_end  = running && (pix_next >= {1'b0, len_q});
  assign start_hit = running && !line_end && (pix == start_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix     <= '0;
      start_q <= '0;
      len_q   <= '0;
      running <= 1'b0;
      wide_q  <= 1'b0;
    end else if (rise_pulse) begin
      pix     <= '0;
      start_q <= start_calc;
      len_q   <= len_calc;
      running <= 1'b1;
      wide_q  <= wide_in;
    end else if (running) begin
      if (line_end) running <= 1'b0;
      else          pix     <= pix_next[PIX_W-1:0];
    end
  end

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> (pix == '0) && running);

  assert_hold_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_pulse |=> $stable(start_q) && $stable(len_q) && $stable(wide_q));

endmodule

// File: rtl/osd_col_cells.sv
module osd_col_cells
  import osd_col_timer_pkg::*;
#(
  parameter int COLS  = 30,
  parameter int DOTS  = 12,
  parameter int COL_W = 5,
  parameter int DOT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_pulse,
  input  logic             line_end,
  input  logic             start_hit,
  input  logic             wide,
  output logic             disp_en,
  output logic [COL_W-1:0] col_idx,
  output logic [DOT_W-1:0] dot_idx
);

  localparam int DC_W = DOT_W + 1;

  col_state_e       st;
  logic [COL_W-1:0] col;
  logic [DC_W-1:0]  dc;
  logic [DC_W-1:0]  dot_last;
  logic [COL_W:0]   col_step;
  logic [COL_W:0]   col_next;
  logic             show;

  assign dot_last = wide ? DC_W'(2 * DOTS - 1) : DC_W'(DOTS - 1);
  assign col_step = wide ? (COL_W+1)'(2) : (COL_W+1)'(1);
  assign col_next = {1'b0, col} + col_step;
  assign show     = (st == CS_SHOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= CS_IDLE;
      col <= '0;
      dc  <= '0;
    end else if (rise_pulse || line_end) begin
      st  <= CS_IDLE;
      col <= '0;
      dc  <= '0;
    end else if (start_hit) begin
      st  <= CS_SHOW;
      col <= '0;
      dc  <= '0;
    end else if (show) begin
      if (dc == dot_last) begin
        dc <= '0;
        if (col_next >= (COL_W+1)'(COLS)) begin
          st  <= CS_IDLE;
          col <= '0;
        end else begin
          col <= col_next[COL_W-1:0];
        end
      end else begin
        dc <= dc + DC_W'(1);
      end
    end
  end

  assign disp_en = show;
  assign col_idx = show ? col : '0;
  assign dot_idx = !show ? '0 : (wide ? dc[DC_W-1:1] : dc[DOT_W-1:0]);

  assert_cell_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    show |-> (col < COL_W'(COLS)) && (dc <= dot_last));

  assert_even_cols_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (show && wide) |-> !col[0]);

  assert_line_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> !disp_en);

  assert_new_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !disp_en);

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !show |-> (col == '0) && (dc == '0));

endmodule

// File: rtl/osd_col_timer.sv
module osd_col_timer
  import osd_col_timer_pkg::*;
#(
  parameter int HPOS_W      = 8,
  parameter int HRES_W      = 8,
  parameter int COLS        = 30,
  parameter int DOTS        = 12,
  parameter int OFS_MUL     = 6,
  parameter int OFS_ADD     = 49,
  parameter int SYNC_STAGES = 2,
  localparam int COL_W      = $clog2(COLS),
  localparam int DOT_W      = $clog2(DOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flyback,
  input  logic [HPOS_W-1:0] hpos,
  input  logic [HRES_W-1:0] hres,
  input  logic              wide_row,
  output logic              disp_en,
  output logic [COL_W-1:0]  col_idx,
  output logic [DOT_W-1:0]  dot_idx
);

  localparam int PIX_W = pix_width(HPOS_W, HRES_W, DOTS, OFS_MUL, OFS_ADD);

  logic rise_pulse;
  logic start_hit;
  logic line_end;
  logic wide_q;

  osd_col_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (flyback),
    .rise_pulse(rise_pulse)
  );

  osd_col_line #(
    .HPOS_W (HPOS_W),
    .HRES_W (HRES_W),
    .DOTS   (DOTS),
    .OFS_MUL(OFS_MUL),
    .OFS_ADD(OFS_ADD),
    .PIX_W  (PIX_W)
  ) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_pulse(rise_pulse),
    .hpos      (hpos),
    .hres      (hres),
    .wide_in   (wide_row),
    .start_hit (start_hit),
    .line_end  (line_end),
    .wide_q    (wide_q)
  );

  osd_col_cells #(
    .COLS (COLS),
    .DOTS (DOTS),
    .COL_W(COL_W),
    .DOT_W(DOT_W)
  ) u_cells (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_pulse(rise_pulse),
    .line_end  (line_end),
    .start_hit (start_hit),
    .wide      (wide_q),
    .disp_en   (disp_en),
    .col_idx   (col_idx),
    .dot_idx   (dot_idx)
  );

endmodule

// File: tb/osd_col_timer_test.sv
`timescale 1ns/1ps
module osd_col_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flyback = 1'b0;
  logic [7:0] hpos = 8'd0;
  logic [7:0] hres = 8'd0;
  logic       wide_row = 1'b0;
  logic       disp_en;
  logic [4:0] col_idx;
  logic [3:0] dot_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string ctx = "";

  // Reference data of the current and the previous line.
  bit have_cur = 1'b0, have_prev = 1'b0;
  int rise_cur = 0, rise_prev = 0;
  int st_cur = 0, st_prev = 0, len_cur = 0, len_prev = 0;
  bit w_cur = 1'b0, w_prev = 1'b0;
  bit seen_on = 1'b0;
  int on_n = 0;

  always #2.5 clk = ~clk;

  osd_col_timer uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .flyback (flyback),
    .hpos    (hpos),
    .hres    (hres),
    .wide_row(wide_row),
    .disp_en (disp_en),
    .col_idx (col_idx),
    .dot_idx (dot_idx)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Expected outputs n rising edges after the edge that first samples the
  // flyback high; position p counts from the detected edge.
  function automatic void model(input int n, input int st, input int len,
                                input bit w, output bit en, output int col,
                                output int dot, output string tag);
    int p;
    int t;
    p = n - 2;
    t = p - 1 - st;
    en = 1'b0; col = 0; dot = 0; tag = "R7";
    if (t >= 0 && t < 360) begin
      if (p >= len) begin
        tag = "R5";
      end else begin
        en = 1'b1;
        if (w) begin
          col = 2 * (t / 24); dot = (t % 24) / 2; tag = "R4";
        end else begin
          col = t / 12; dot = t % 12; tag = "R3";
        end
      end
    end
  endfunction

  task automatic check(input string tag, input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      bit en;
      int col;
      int dot;
      string tag;
      en = 1'b0; col = 0; dot = 0; tag = "R9";
      if (have_cur && (cyc - rise_cur) >= 2)
        model(cyc - rise_cur, st_cur, len_cur, w_cur, en, col, dot, tag);
      else if (have_prev)
        model(cyc - rise_prev, st_prev, len_prev, w_prev, en, col, dot, tag);
      check({tag, ctx}, (disp_en == en) && (col_idx == col) && (dot_idx == dot),
            $sformatf("cyc %0d got en=%0d col=%0d dot=%0d exp en=%0d col=%0d dot=%0d",
                      cyc, disp_en, col_idx, dot_idx, en, col, dot));
      if (disp_en && !seen_on) begin
        seen_on = 1'b1;
        on_n = cyc - rise_cur;
      end
    end
  end

  // One line: settings and rising flyback applied at a falling edge.
  task automatic line(input int hp, input int hr, input bit w, input int hold,
                      input int len);
    @(negedge clk);
    hpos = 8'(hp); hres = 8'(hr); wide_row = w;
    flyback = 1'b1;
    have_prev = have_cur; rise_prev = rise_cur;
    st_prev = st_cur; len_prev = len_cur; w_prev = w_cur;
    have_cur = 1'b1; rise_cur = cyc + 1;
    st_cur = hp * 6 + 49; len_cur = hr * 12; w_cur = w;
    seen_on = 1'b0;
    repeat (hold) @(negedge clk);
    flyback = 1'b0;
    repeat (len - hold) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", !disp_en && col_idx == 0 && dot_idx == 0,
          $sformatf("in reset got en=%0d col=%0d dot=%0d exp 0 0 0",
                    disp_en, col_idx, dot_idx));
    rst_n = 1'b1;
    checking = 1'b1;
    repeat (20) @(negedge clk);

    // R1, R2: first lit dot after the offset, smallest and larger offsets
    ctx = "/R1";
    line(0, 255, 1'b0, 4, 3100);
    check("R1", seen_on && on_n == 52,
          $sformatf("first dot at n=%0d exp 52", on_n));
    ctx = "/R2";
    line(37, 255, 1'b1, 3, 3100);
    check("R2", seen_on && on_n == 37 * 6 + 52,
          $sformatf("first dot at n=%0d exp %0d", on_n, 37 * 6 + 52));

    // R5: short line clips the run; line shorter than the offset shows nothing
    ctx = "/R5";
    line(0, 30, 1'b0, 2, 500);
    line(20, 10, 1'b1, 2, 400);
    check("R5", !seen_on, $sformatf("display seen=%0d exp 0", seen_on));

    // R6: new flyback in the middle of a run
    ctx = "/R6";
    line(5, 200, 1'b0, 3, 250);
    line(2, 200, 1'b1, 3, 700);

    // R10: flyback held high across the whole run
    ctx = "/R10";
    line(3, 100, 1'b0, 900, 1300);

    // R8: settings changed mid-line have no effect on the running line
    ctx = "/R8";
    line(10, 120, 1'b0, 3, 200);
    hpos = 8'd0; hres = 8'd20; wide_row = 1'b1;
    repeat (1300) @(negedge clk);
    line(1, 120, 1'b1, 3, 150);
    hpos = 8'd200; hres = 8'd5; wide_row = 1'b0;
    repeat (1300) @(negedge clk);

    // Random lines
    ctx = "/rand";
    for (int i = 0; i < 28; i++) begin
      int hr;
      int hp;
      int ln;
      hr = $urandom_range(20, 255);
      hp = $urandom_range(0, 90);
      ln = $urandom_range(200, hr * 12 + 40);
      line(hp, hr, 1'($urandom_range(0, 1)), $urandom_range(1, 8), ln);
    end
    repeat (50) @(negedge clk);

    checking = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule